// File: doc/BRIEF.md
# SIMD saturating rounding doubling multiply-accumulate unit

This unit treats three 128-bit operands as packed signed lanes. The operands are a multiplicand, a multiplier and an accumulator. For every active lane it doubles the exact product of the two multiplied lanes. It then adds that doubled product to, or subtracts it from, the accumulator lane shifted up by the lane width. A rounding term of half a lane unit is added at the same time. All of this is done at full precision. The upper half of that sum is then clamped once to the signed lane range and returned as the lane result. A per-operation pulse reports whether any active lane was clamped. A sticky flag keeps that information until software clears it.

A two-bit lane code picks the lane width, which is 8 shifted left by the code. Code 01 selects 16-bit lanes and code 10 selects 32-bit lanes. Codes 00 and 11 are rejected: they raise an illegal-size pulse and produce no result. In vector mode the width select chooses 64 or 128 bits of data. In scalar mode only lane 0 is processed. Result bits outside the processed lanes are always zero. The unit has a single register stage: every output is updated on the clock edge that samples `in_valid`.

The sticky flag is a two-state machine with states CLEAR and SET. The ARM transition goes from CLEAR to SET when an accepted operation saturates. The RELEASE transition goes from SET to CLEAR when `sat_clear` is high and no saturation arrives in the same cycle. In every other cycle the HOLD transition keeps the current state.

Top module: `sqrd_mac`

## Requirements
- R1: Lane code 01 selects 16-bit lanes and code 10 selects 32-bit lanes. For an accepted operation with code 00 or 11, the unit raises `illegal_size` for one cycle, drives `result` to zero, keeps `op_sat` low and leaves `sticky_sat` unchanged.
- R2: With `subtract` low, each active lane result is the upper half of (acc << w) + 2·a·b + 2^(w−1), computed exactly, where w is the lane width. Lane i occupies bits [i·w +: w].
- R3: With `subtract` high, the doubled product is subtracted instead of added. The rounding term is still added.
- R4: In vector mode, `full_width` = 0 processes the lower 64 bits and drives result bits 127:64 to zero. `full_width` = 1 processes all 128 bits.
- R5: With `scalar_mode` high, only lane 0 is computed, whatever the value of `full_width`. All other result bits are zero.
- R6: When the upper half lies outside the signed lane range, the lane result is clamped to the lane maximum or minimum and `op_sat` is high. For example, with 0x8000 in both multiplied lanes and a zero accumulator, the result is 0x7FFF.
- R7: `sticky_sat` becomes 1 in the same cycle as any `op_sat` pulse and stays at 1 until it is cleared. Saturation in inactive lanes has no effect.
- R8: `sat_clear` returns `sticky_sat` to 0 on the next edge. A saturating operation accepted in the same cycle takes priority, so the flag stays at 1.
- R9: `out_valid`, `result`, `op_sat` and `illegal_size` update exactly one clock after `in_valid`. Back-to-back operations are accepted every cycle. In a cycle without `in_valid`, `out_valid`, `op_sat` and `illegal_size` are 0 and `result` keeps its previous value.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| src_a | input | 128 | Multiplicand lanes |
| src_b | input | 128 | Multiplier lanes |
| src_acc | input | 128 | Accumulator lanes |
| lane_code | input | 2 | Lane width code (01 = 16-bit, 10 = 32-bit) |
| full_width | input | 1 | Vector data width: 0 = 64 bits, 1 = 128 bits |
| scalar_mode | input | 1 | Process lane 0 only |
| subtract | input | 1 | Subtract the doubled product instead of adding it |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 128 | Packed lane results |
| op_sat | output | 1 | The last accepted operation saturated in some lane |
| sticky_sat | output | 1 | Cumulative saturation flag |
| illegal_size | output | 1 | The last accepted operation had an illegal lane code |

## Verification
Mixed-sign operands are run through both lane widths and both vector widths. This separates the lane slicing and the zeroing of the upper half from the core arithmetic. Add and subtract runs, with operands chosen so that the result depends on the rounding term, show whether the sign of the product term and the rounding are applied correctly. Both clamp directions are exercised: most-negative squared with an add drives the result to the maximum, and a large subtracted product drives it to the minimum. A saturating pattern placed only in the unprocessed lanes confirms that inactive lanes do not report saturation. Illegal codes carrying saturating data, together with clear and saturation arriving in the same cycle, separate the priority and hold behaviour of the sticky state machine.

// File: rtl/sqrd_pkg.sv
package sqrd_pkg;

    typedef enum logic [1:0] {
        LANE_RSV_LO = 2'b00,
        LANE_HALF   = 2'b01,
        LANE_WORD   = 2'b10,
        LANE_RSV_HI = 2'b11
    } lane_code_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_SET   = 1'b1
    } sticky_state_e;

endpackage

// File: rtl/sqrd_lane.sv
module sqrd_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] acc,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         sat
);
    localparam int IW = 2 * W + 2;
    localparam int HW = IW - W;
    localparam logic signed [HW-1:0] HI_MAX = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [HW-1:0] HI_MIN = {3'b111, {(W-1){1'b0}}};
    localparam logic signed [IW-1:0] RND    = {{(IW-W){1'b0}}, 1'b1, {(W-1){1'b0}}};

    logic signed [2*W-1:0] prod;
    logic signed [IW-1:0]  acc_sh;
    logic signed [IW-1:0]  prod2;
    logic signed [IW-1:0]  total;
    logic signed [HW-1:0]  hi;
    logic                  lane_unused;

    always_comb begin
        prod   = $signed(a) * $signed(b);
        acc_sh = IW'($signed(acc)) <<< W;
        prod2  = IW'(prod) <<< 1;
        total  = sub ? (acc_sh - prod2 + RND) : (acc_sh + prod2 + RND);
        hi     = total[IW-1:W];
    end

    assign lane_unused = ^total[W-1:0];

    always_comb begin
        if (hi > HI_MAX) begin
            res = {1'b0, {(W-1){1'b1}}};
            sat = 1'b1;
        end else if (hi < HI_MIN) begin
            res = {1'b1, {(W-1){1'b0}}};
            sat = 1'b1;
        end else begin
            res = hi[W-1:0];
            sat = 1'b0;
        end
    end

    always_comb begin
        // R6
        if (sat) begin
            sat_clamp_chk: assert (res == {1'b0, {(W-1){1'b1}}} || res == {1'b1, {(W-1){1'b0}}});
        end
    end

endmodule

// File: rtl/sqrd_lane_bank.sv
module sqrd_lane_bank #(
    parameter int DATA_W = 128,
    parameter int W      = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] acc,
    input  logic              sub,
    input  logic              scalar_mode,
    input  logic              full_width,
    output logic [DATA_W-1:0] res,
    output logic              sat_any
);
    localparam int N    = DATA_W / W;
    localparam int HALF = N / 2;

    logic [N-1:0] sat_vec;

    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam bit IS_FIRST = (i == 0);
        localparam bit IS_LOWER = (i < HALF);
        logic [W-1:0] l_res;
        logic         l_sat;
        logic         active;

        sqrd_lane #(.W(W)) u_lane (
            .a   (a[i*W +: W]),
            .b   (b[i*W +: W]),
            .acc (acc[i*W +: W]),
            .sub (sub),
            .res (l_res),
            .sat (l_sat)
        );

        assign active         = scalar_mode ? IS_FIRST : (full_width || IS_LOWER);
        assign res[i*W +: W]  = active ? l_res : '0;
        assign sat_vec[i]     = active & l_sat;
    end

    assign sat_any = |sat_vec;

endmodule

// File: rtl/sqrd_sticky.sv
module sqrd_sticky
    import sqrd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    sticky_state_e state_q;
    sticky_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_CLEAR: state_d = set_evt ? ST_SET : ST_CLEAR;
            ST_SET:   state_d = (clr_evt && !set_evt) ? ST_CLEAR : ST_SET;
            default:  state_d = ST_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == ST_SET);
    end

    // R7
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_evt));

endmodule

// File: rtl/sqrd_mac.sv
module sqrd_mac
    import sqrd_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_acc,
    input  logic [1:0]        lane_code,
    input  logic              full_width,
    input  logic              scalar_mode,
    input  logic              subtract,
    input  logic              sat_clear,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              op_sat,
    output logic              sticky_sat,
    output logic              illegal_size
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] n_res;
    logic [DATA_W-1:0] w_res;
    logic              n_sat;
    logic              w_sat;
    logic              legal;
    logic              pick_narrow;
    logic [DATA_W-1:0] comb_res;
    logic              comb_sat;

    sqrd_lane_bank #(.DATA_W(DATA_W), .W(NARROW_W)) u_narrow (
        .a           (src_a),
        .b           (src_b),
        .acc         (src_acc),
        .sub         (subtract),
        .scalar_mode (scalar_mode),
        .full_width  (full_width),
        .res         (n_res),
        .sat_any     (n_sat)
    );

    sqrd_lane_bank #(.DATA_W(DATA_W), .W(WIDE_W)) u_wide (
        .a           (src_a),
        .b           (src_b),
        .acc         (src_acc),
        .sub         (subtract),
        .scalar_mode (scalar_mode),
        .full_width  (full_width),
        .res         (w_res),
        .sat_any     (w_sat)
    );

    always_comb begin
        unique case (lane_code_e'(lane_code))
            LANE_HALF: begin legal = 1'b1; pick_narrow = 1'b1; end
            LANE_WORD: begin legal = 1'b1; pick_narrow = 1'b0; end
            default:   begin legal = 1'b0; pick_narrow = 1'b0; end
        endcase
        if (!legal)          comb_res = '0;
        else if (pick_narrow) comb_res = n_res;
        else                  comb_res = w_res;
        comb_sat = legal && (pick_narrow ? n_sat : w_sat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            op_sat       <= 1'b0;
            illegal_size <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            op_sat       <= in_valid & comb_sat;
            illegal_size <= in_valid & ~legal;
            if (in_valid) result <= comb_res;
        end
    end

    sqrd_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (in_valid & comb_sat),
        .clr_evt (sat_clear),
        .flag    (sticky_sat)
    );

    // R9
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_size |-> (result == '0 && !op_sat));

    // R7
    sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sat |-> sticky_sat);

    // R4
    half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!full_width || scalar_mode)) |=> (result[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/tb_sqrd_mac.sv
`timescale 1ns/1ps
module tb_sqrd_mac;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, src_acc = '0;
    logic [1:0]   lane_code = 2'b01;
    logic         full_width = 1'b0, scalar_mode = 1'b0, subtract = 1'b0, sat_clear = 1'b0;
    logic         out_valid, op_sat, sticky_sat, illegal_size;
    logic [127:0] result;

    sqrd_mac dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .src_acc(src_acc),
        .lane_code(lane_code), .full_width(full_width), .scalar_mode(scalar_mode),
        .subtract(subtract), .sat_clear(sat_clear),
        .out_valid(out_valid), .result(result), .op_sat(op_sat),
        .sticky_sat(sticky_sat), .illegal_size(illegal_size)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [127:0] r;
        bit           s;
        bit           ill;
        bit           st;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    int           n_chk = 0;
    int           n_fail = 0;
    bit           model_sticky = 0;
    bit           done = 0;
    logic [127:0] last_res = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                  input logic [127:0] c, input logic [1:0] sz,
                                  input bit wd, input bit sc, input bit neg,
                                  output logic [127:0] r, output bit s, output bit ill);
        int es, n;
        logic signed [71:0] x1, x2, x3, t, h, mx, mn;
        r = '0; s = 0;
        ill = (sz == 2'b00 || sz == 2'b11);
        if (ill) return;
        es = 8 << sz;
        n  = sc ? 1 : ((wd ? 128 : 64) / es);
        mx = (72'sd1 <<< (es - 1)) - 72'sd1;
        mn = -(72'sd1 <<< (es - 1));
        for (int e = 0; e < n; e++) begin
            if (es == 16) begin
                x1 = 72'($signed(a[e*16 +: 16]));
                x2 = 72'($signed(b[e*16 +: 16]));
                x3 = 72'($signed(c[e*16 +: 16]));
            end else begin
                x1 = 72'($signed(a[e*32 +: 32]));
                x2 = 72'($signed(b[e*32 +: 32]));
                x3 = 72'($signed(c[e*32 +: 32]));
            end
            t = (x3 <<< es) + (neg ? -(72'sd2 * x1 * x2) : (72'sd2 * x1 * x2)) + (72'sd1 <<< (es - 1));
            h = t >>> es;
            if (h > mx) begin h = mx; s = 1; end
            else if (h < mn) begin h = mn; s = 1; end
            if (es == 16) r[e*16 +: 16] = h[15:0];
            else          r[e*32 +: 32] = h[31:0];
        end
    endfunction

    task automatic op(input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                      input logic [1:0] sz, input bit wd, input bit sc, input bit neg,
                      input bit clr, input string tag);
        exp_t it;
        @(negedge clk);
        src_a = a; src_b = b; src_acc = c; lane_code = sz;
        full_width = wd; scalar_mode = sc; subtract = neg; sat_clear = clr;
        in_valid = 1'b1;
        model(a, b, c, sz, wd, sc, neg, it.r, it.s, it.ill);
        if (it.s) model_sticky = 1;
        else if (clr) model_sticky = 0;
        it.st = model_sticky;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; sat_clear = 1'b0;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R9", "unexpected out_valid", 128'd1, 128'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(result == e.r, e.tag, "result", result, e.r);
                chk(op_sat == e.s, e.tag, "op_sat", 128'(op_sat), 128'(e.s));
                chk(illegal_size == e.ill, e.tag, "illegal_size", 128'(illegal_size), 128'(e.ill));
                chk(sticky_sat == e.st, e.tag, "sticky_sat", 128'(sticky_sat), 128'(e.st));
                last_res = e.r;
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    localparam logic [127:0] A1 = 128'h7FFF_8001_1234_FEDC_0100_FF00_0003_8000;
    localparam logic [127:0] B1 = 128'h0002_7FFF_ABCD_0456_0100_00FF_FFFD_4000;
    localparam logic [127:0] C1 = 128'h0001_FFFF_8000_7FFE_1234_0000_FFFF_0010;
    localparam logic [127:0] MN16 = {8{16'h8000}};
    localparam logic [127:0] MX16 = {8{16'h7FFF}};
    localparam logic [127:0] MN32 = {4{32'h8000_0000}};

    initial begin
        // R10: reset state
        #1;
        repeat (2) @(negedge clk);
        chk(out_valid == 0 && op_sat == 0 && illegal_size == 0 && sticky_sat == 0,
            "R10", "reset flags", {out_valid, op_sat, illegal_size, sticky_sat}, 128'd0);
        chk(result == '0, "R10", "reset result", result, 128'd0);
        rst_n = 1'b1;
        idle(2);

        // R2 R4: 16-bit lanes, full and half width, add
        op(A1, B1, C1, 2'b01, 1, 0, 0, 0, "R2 h128");
        op(A1, B1, C1, 2'b01, 0, 0, 0, 0, "R4 h64");
        // R2 R4: 32-bit lanes
        op(A1, B1, C1, 2'b10, 1, 0, 0, 0, "R2 w128");
        op(C1, A1, B1, 2'b10, 0, 0, 0, 0, "R4 w64");
        // R3: subtract
        op(A1, B1, C1, 2'b01, 1, 0, 1, 0, "R3 h128 sub");
        op(B1, C1, A1, 2'b10, 1, 0, 1, 0, "R3 w128 sub");
        // R5: scalar mode ignores full_width
        op(A1, B1, C1, 2'b01, 1, 1, 0, 0, "R5 scalar h");
        op(A1, B1, C1, 2'b10, 0, 1, 1, 0, "R5 scalar w");
        // R7: saturation only in inactive upper lanes
        op({{4{16'h8000}}, 64'h0003_0002_0001_0004}, {{4{16'h8000}}, 64'h0005_0006_0007_0008},
           '0, 2'b01, 0, 0, 0, 0, "R7 inactive sat");
        idle(2);
        // R9: idle hold
        chk(out_valid == 0 && op_sat == 0 && illegal_size == 0, "R9", "idle pulses",
            {out_valid, op_sat, illegal_size}, 128'd0);
        chk(result == last_res, "R9", "result hold", result, last_res);

        // R6: most-negative squared saturates high, sets sticky
        op(MN16, MN16, '0, 2'b01, 1, 0, 0, 0, "R6 max clamp h");
        op(MN32, MN32, '0, 2'b10, 1, 0, 0, 0, "R6 max clamp w");
        // R6: negative clamp via subtract
        op(MX16, MX16, MN16, 2'b01, 1, 0, 1, 0, "R6 min clamp");
        // R7: non-saturating op keeps sticky
        op(A1, B1, C1, 2'b01, 0, 0, 0, 0, "R7 sticky hold");
        // R1: illegal codes with saturating data, sticky unchanged (1)
        op(MN16, MN16, '0, 2'b00, 1, 0, 0, 0, "R1 code00");
        op(MN16, MN16, '0, 2'b11, 1, 0, 0, 0, "R1 code11");
        idle(2);

        // R8: clear alone
        @(negedge clk);
        in_valid = 1'b0; sat_clear = 1'b1; model_sticky = 0;
        @(negedge clk);
        sat_clear = 1'b0;
        chk(sticky_sat == 0, "R8", "clear", 128'(sticky_sat), 128'd0);
        // R1: illegal with saturating data keeps sticky at 0
        op(MN16, MN16, '0, 2'b11, 1, 0, 0, 0, "R1 code11 clear");
        // R8: clear and saturation together -> set wins
        op(MN16, MN16, '0, 2'b01, 1, 0, 0, 1, "R8 clr+sat");
        // R8: clear with non-saturating op -> cleared
        op(A1, B1, C1, 2'b10, 1, 0, 0, 1, "R8 clr+op");
        idle(3);

        while (sb.size() != 0) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule